// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block holds the power state of a small processor system and drives the enables for each gated domain in that state. The domains are the CPU clock, the peripheral clock, the main oscillator, the low-power RC oscillator, the clock-failure monitor, the I/O freeze and the SRAM/Flash supply. Software issues a power-save command whose operand selects idle or sleep. An armed deep-sleep bit turns a sleep command into deep sleep. Interrupts that are individually enabled, a watchdog time-out, a deep-sleep watchdog time-out and reset wake the system, and each low-power state accepts its own set of these.

The block has five states. `ST_RUN` is the normal state. `ST_IDLE` stops only the CPU. `ST_SLEEP` stops the system clock source and freezes I/O. `ST_DEEP` also removes memory power. `ST_DS_EXIT` is a one-cycle recovery step that restores memory power while the clocks stay off.

The transitions are:
- RUN→IDLE on an idle command.
- RUN→SLEEP on a sleep command while the deep-sleep bit is clear.
- RUN→DEEP on a sleep command while the deep-sleep bit is set.
- IDLE→RUN and SLEEP→RUN on a lightweight wake.
- DEEP→DS_EXIT on a deep-sleep watchdog time-out.
- DS_EXIT→RUN unconditionally.
- Any state→RUN on reset.

The clock-source selector is saved when the system enters sleep or deep sleep, and it is restored on wake.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in run. `cpu_clk_en`, `per_clk_en`, `mosc_en`, `lprc_en`, `fscm_en` and `mem_pwr_en` are 1. `io_freeze`, `wdt_clr` and `deep_arm` are 0. `clk_sel` equals the parameter `RST_SEL`.
- R2: In run, a command pulse (`save_valid`=1) with `save_mode`=0 (idle) moves the block to idle at the next edge. In idle only `cpu_clk_en` is 0, and every other enable keeps its run value.
- R3: In run, a command with `save_mode`=1 (sleep) while `deep_arm`=0 moves the block to sleep at the next edge. In sleep `cpu_clk_en`, `per_clk_en`, `mosc_en` and `fscm_en` are 0, `io_freeze` is 1 and `mem_pwr_en` stays 1.
- R4: A sleep command while `deep_arm`=1 enters deep sleep, which has the sleep outputs plus `mem_pwr_en`=0. An idle command while `deep_arm`=1 still enters idle.
- R5: In idle or sleep, an interrupt with both request and enable high, or `wdt_timeout`, returns the block to run at the next edge.
- R6: A requesting interrupt whose enable is 0 has no effect in any state. A command issued while one is pending still enters its low-power state.
- R7: `wdt_clr` is high for exactly the first cycle of sleep when `wdt_en`=1. It stays low for idle entry, for deep-sleep entry, and when `wdt_en`=0.
- R8: In sleep, deep sleep and deep-sleep exit, `lprc_en` equals `lprc_user_wdt` OR `lprc_user_rtc`. In run and idle it is 1.
- R9: `clk_sel_wr` loads `clk_sel_wdata` only in run. In sleep, deep sleep and deep-sleep exit, `clk_sel` shows `PARK_SEL`. On return to run it shows the value held before entry.
- R10: Deep sleep ignores interrupts and `wdt_timeout`. A `dswdt_timeout` moves the block to a one-cycle exit state with `mem_pwr_en`=1, the clocks still off and I/O still frozen, and clears `deep_arm`. Run follows on the next edge.
- R11: Asserting `rst_n` low from any state returns every output to its R1 value at once, without waiting for a clock edge.
- R12: A power-save command or a write to the deep-sleep bit issued outside run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| save_valid | input | 1 | Power-save command strobe |
| save_mode | input | 1 | Command operand: 0 idle, 1 sleep |
| deep_arm_wr | input | 1 | Write strobe for the deep-sleep bit |
| deep_arm_wdata | input | 1 | Value written to the deep-sleep bit |
| clk_sel_wr | input | 1 | Write strobe for the clock-source selector |
| clk_sel_wdata | input | SEL_W | New clock-source selector value |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| wdt_en | input | 1 | Watchdog is enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| dswdt_timeout | input | 1 | Deep-sleep watchdog time-out |
| lprc_user_wdt | input | 1 | Watchdog is enabled and clocked from the RC oscillator |
| lprc_user_rtc | input | 1 | Real-time clock is enabled and clocked from the RC oscillator |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mosc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| fscm_en | output | 1 | Clock-failure monitor enable |
| io_freeze | output | 1 | Holds I/O directions and levels |
| mem_pwr_en | output | 1 | SRAM/Flash supply enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| clk_sel | output | SEL_W | Clock-source selector presented to the clock tree |
| deep_arm | output | 1 | Current value of the deep-sleep bit |

## Verification
The idle and sleep commands are each tried with the deep-sleep bit clear and set. This separates the four entry paths and shows whether the memory supply is cut only in the deep path. Each wake source is applied in every state: an enabled interrupt, a disabled but requesting interrupt, the watchdog time-out and the deep-sleep time-out. This shows that deep sleep has its own wake set and that a masked request neither wakes the block nor blocks entry. A selector write during sleep, followed by a wake, distinguishes restoring the saved source from following the write bus. An asynchronous reset applied in the middle of sleep checks that recovery needs no clock edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_SLEEP   = 3'd2,
        ST_DEEP    = 3'd3,
        ST_DS_EXIT = 3'd4
    } pwr_state_e;

    localparam logic MODE_IDLE  = 1'b0;
    localparam logic MODE_SLEEP = 1'b1;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             dswdt_timeout,
    output logic             lp_wake,
    output logic             ds_wake
);
    logic [N_IRQ-1:0] armed_src;

    // One qualifying gate per interrupt source.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        assign armed_src[g] = irq_req[g] & irq_en[g];
    end

    assign lp_wake = (|armed_src) | wdt_timeout;
    assign ds_wake = dswdt_timeout;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       save_valid,
    input  logic       save_mode,
    input  logic       deep_arm_wr,
    input  logic       deep_arm_wdata,
    input  logic       lp_wake,
    input  logic       ds_wake,
    output pwr_state_e state,
    output logic       enter_sleep,
    output logic       deep_arm
);
    pwr_state_e state_q, state_d;
    logic       arm_q, arm_d;

    always_comb begin
        state_d = state_q;
        arm_d   = arm_q;
        unique case (state_q)
            ST_RUN: begin
                if (deep_arm_wr) arm_d = deep_arm_wdata;
                if (save_valid) begin
                    if (save_mode == MODE_IDLE) state_d = ST_IDLE;
                    else if (arm_q)             state_d = ST_DEEP;
                    else                        state_d = ST_SLEEP;
                end
            end
            ST_IDLE, ST_SLEEP: begin
                if (lp_wake) state_d = ST_RUN;
            end
            ST_DEEP: begin
                if (ds_wake) begin
                    state_d = ST_DS_EXIT;
                    arm_d   = 1'b0;
                end
            end
            ST_DS_EXIT: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
        end
    end

    assign state       = state_q;
    assign deep_arm    = arm_q;
    assign enter_sleep = (state_q == ST_RUN) && (state_d == ST_SLEEP);

    a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && save_valid && save_mode == MODE_IDLE) |=> state_q == ST_IDLE);
    a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && save_valid && save_mode == MODE_SLEEP && !arm_q) |=> state_q == ST_SLEEP);
    a_r5_lp_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_SLEEP) && lp_wake) |=> state_q == ST_RUN);
    a_r10_deep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP && !ds_wake) |=> state_q == ST_DEEP);
    a_r10_exit_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DS_EXIT) |=> (state_q == ST_RUN && !arm_q));
    a_r12_arm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_SLEEP) |=> $stable(arm_q));
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int               SEL_W    = 3,
    parameter logic [SEL_W-1:0] RST_SEL  = 1,
    parameter logic [SEL_W-1:0] PARK_SEL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwr_state_e       state,
    input  logic             enter_sleep,
    input  logic             wdt_en,
    input  logic             lprc_user_wdt,
    input  logic             lprc_user_rtc,
    input  logic             clk_sel_wr,
    input  logic [SEL_W-1:0] clk_sel_wdata,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             mosc_en,
    output logic             lprc_en,
    output logic             fscm_en,
    output logic             io_freeze,
    output logic             mem_pwr_en,
    output logic             wdt_clr,
    output logic [SEL_W-1:0] clk_sel
);
    logic [SEL_W-1:0] sel_q;
    logic             clr_q;
    logic             lprc_keep;

    assign lprc_keep = lprc_user_wdt | lprc_user_rtc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= RST_SEL;
            clr_q <= 1'b0;
        end else begin
            if (state == ST_RUN && clk_sel_wr) sel_q <= clk_sel_wdata;
            clr_q <= enter_sleep & wdt_en;
        end
    end

    always_comb begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        mosc_en    = 1'b0;
        fscm_en    = 1'b0;
        lprc_en    = lprc_keep;
        io_freeze  = 1'b1;
        mem_pwr_en = 1'b1;
        clk_sel    = PARK_SEL;
        unique case (state)
            ST_RUN, ST_IDLE: begin
                cpu_clk_en = (state == ST_RUN);
                per_clk_en = 1'b1;
                mosc_en    = 1'b1;
                fscm_en    = 1'b1;
                lprc_en    = 1'b1;
                io_freeze  = 1'b0;
                clk_sel    = sel_q;
            end
            ST_SLEEP, ST_DS_EXIT: ;
            ST_DEEP:              mem_pwr_en = 1'b0;
            default:              ;
        endcase
    end

    assign wdt_clr = clr_q;

    a_r7_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);
    a_r7_clr_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> state == ST_SLEEP);
    a_r9_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> $stable(sel_q));
    a_r4_mem_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pwr_en |-> (io_freeze && !cpu_clk_en && !per_clk_en));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int               N_IRQ    = 8,
    parameter int               SEL_W    = 3,
    parameter logic [SEL_W-1:0] RST_SEL  = 1,
    parameter logic [SEL_W-1:0] PARK_SEL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_valid,
    input  logic             save_mode,
    input  logic             deep_arm_wr,
    input  logic             deep_arm_wdata,
    input  logic             clk_sel_wr,
    input  logic [SEL_W-1:0] clk_sel_wdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_en,
    input  logic             wdt_timeout,
    input  logic             dswdt_timeout,
    input  logic             lprc_user_wdt,
    input  logic             lprc_user_rtc,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             mosc_en,
    output logic             lprc_en,
    output logic             fscm_en,
    output logic             io_freeze,
    output logic             mem_pwr_en,
    output logic             wdt_clr,
    output logic [SEL_W-1:0] clk_sel,
    output logic             deep_arm
);
    logic       lp_wake, ds_wake, enter_sleep;
    pwr_state_e state;

    pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req       (irq_req),
        .irq_en        (irq_en),
        .wdt_timeout   (wdt_timeout),
        .dswdt_timeout (dswdt_timeout),
        .lp_wake       (lp_wake),
        .ds_wake       (ds_wake)
    );

    pwr_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .save_valid     (save_valid),
        .save_mode      (save_mode),
        .deep_arm_wr    (deep_arm_wr),
        .deep_arm_wdata (deep_arm_wdata),
        .lp_wake        (lp_wake),
        .ds_wake        (ds_wake),
        .state          (state),
        .enter_sleep    (enter_sleep),
        .deep_arm       (deep_arm)
    );

    pwr_domain_ctrl #(.SEL_W(SEL_W), .RST_SEL(RST_SEL), .PARK_SEL(PARK_SEL)) u_dom (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .enter_sleep   (enter_sleep),
        .wdt_en        (wdt_en),
        .lprc_user_wdt (lprc_user_wdt),
        .lprc_user_rtc (lprc_user_rtc),
        .clk_sel_wr    (clk_sel_wr),
        .clk_sel_wdata (clk_sel_wdata),
        .cpu_clk_en    (cpu_clk_en),
        .per_clk_en    (per_clk_en),
        .mosc_en       (mosc_en),
        .lprc_en       (lprc_en),
        .fscm_en       (fscm_en),
        .io_freeze     (io_freeze),
        .mem_pwr_en    (mem_pwr_en),
        .wdt_clr       (wdt_clr),
        .clk_sel       (clk_sel)
    );
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
    localparam int CLK_PER = 10;
    localparam int NI = 8;
    localparam int SW = 3;
    localparam logic [SW-1:0] RSEL = 3'd1;
    localparam logic [SW-1:0] PSEL = 3'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic save_valid = 0, save_mode = 0, deep_arm_wr = 0, deep_arm_wdata = 0;
    logic clk_sel_wr = 0;
    logic [SW-1:0] clk_sel_wdata = '0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic wdt_en = 0, wdt_timeout = 0, dswdt_timeout = 0, lprc_user_wdt = 0, lprc_user_rtc = 0;
    logic cpu_clk_en, per_clk_en, mosc_en, lprc_en, fscm_en, io_freeze, mem_pwr_en, wdt_clr, deep_arm;
    logic [SW-1:0] clk_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    pwr_mode_seq #(.N_IRQ(NI), .SEL_W(SW), .RST_SEL(RSEL), .PARK_SEL(PSEL)) dut_i (.*);

    // Behavioural reference: 0 run, 1 idle, 2 sleep, 3 deep, 4 deep exit.
    int m_st;
    bit m_arm, m_clr;
    logic [SW-1:0] m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_arm = 0; m_clr = 0; m_sel = RSEL;
        end else begin
            bit wake;
            wake = ((irq_req & irq_en) != 0) || wdt_timeout;
            m_clr = 0;
            if (m_st == 0) begin
                if (save_valid) begin
                    if (!save_mode) m_st = 1;
                    else if (m_arm) m_st = 3;
                    else begin m_st = 2; m_clr = wdt_en; end
                end
                if (clk_sel_wr) m_sel = clk_sel_wdata;
                if (deep_arm_wr) m_arm = deep_arm_wdata;
            end else if (m_st == 1 || m_st == 2) begin
                if (wake) m_st = 0;
            end else if (m_st == 3) begin
                if (dswdt_timeout) begin m_st = 4; m_arm = 0; end
            end else m_st = 0;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("R2 cpu_clk_en", cpu_clk_en, m_st == 0);
        chk("R3 per_clk_en", per_clk_en, m_st <= 1);
        chk("R3 mosc_en", mosc_en, m_st <= 1);
        chk("R3 fscm_en", fscm_en, m_st <= 1);
        chk("R3 io_freeze", io_freeze, m_st >= 2);
        chk("R4 mem_pwr_en", mem_pwr_en, m_st != 3);
        chk("R8 lprc_en", lprc_en, (m_st <= 1) ? 1'b1 : (lprc_user_wdt | lprc_user_rtc));
        chk("R7 wdt_clr", wdt_clr, m_clr);
        chk("R9 clk_sel", clk_sel, (m_st >= 2) ? PSEL : m_sel);
        chk("R10 deep_arm", deep_arm, m_arm);
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic cmd(logic mode);
        save_valid = 1; save_mode = mode; tick(); save_valid = 0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        tick(); tick(); rst_n = 1; tick();
        chk("R1 reset enables", {cpu_clk_en, per_clk_en, mosc_en, lprc_en, fscm_en, mem_pwr_en}, 8'h3f);
        chk("R1 reset others", {io_freeze, wdt_clr, deep_arm}, 8'h0);
        chk("R1 reset sel", clk_sel, RSEL);
        clk_sel_wr = 1; clk_sel_wdata = 3'd5; tick(); clk_sel_wr = 0;
        chk("R9 sel write in run", clk_sel, 3'd5);
        // Idle with a masked pending request, then wake by enabling it.
        irq_req = 8'h04; wdt_en = 1;
        cmd(1'b0);
        chk("R2 idle cpu off", cpu_clk_en, 0);
        chk("R2 idle per on", per_clk_en, 1);
        chk("R7 no clear on idle", wdt_clr, 0);
        tick(); tick();
        chk("R6 masked irq no wake", cpu_clk_en, 0);
        save_valid = 1; save_mode = 1; deep_arm_wr = 1; deep_arm_wdata = 1; tick();
        save_valid = 0; deep_arm_wr = 0;
        chk("R12 command ignored in idle", {per_clk_en, io_freeze, deep_arm}, 8'h4);
        irq_en = 8'h04; tick(); irq_en = 0;
        chk("R5 wake from idle on irq", cpu_clk_en, 1);
        // Sleep with masked pending request, watchdog enabled.
        cmd(1'b1);
        chk("R6 entry not blocked", io_freeze, 1);
        chk("R3 sleep clocks", {cpu_clk_en, per_clk_en, mosc_en, fscm_en, mem_pwr_en}, 8'h1);
        chk("R7 clear pulse", wdt_clr, 1);
        chk("R8 lprc off no users", lprc_en, 0);
        chk("R9 parked sel", clk_sel, PSEL);
        lprc_user_rtc = 1; clk_sel_wr = 1; clk_sel_wdata = 3'd2; tick(); clk_sel_wr = 0;
        chk("R7 clear single cycle", wdt_clr, 0);
        chk("R8 lprc kept by rtc", lprc_en, 1);
        wdt_timeout = 1; tick(); wdt_timeout = 0; lprc_user_rtc = 0;
        chk("R5 wake from sleep on wdt", cpu_clk_en, 1);
        chk("R9 sel restored", clk_sel, 3'd5);
        // Sleep with watchdog disabled: no clear.
        wdt_en = 0; cmd(1'b1);
        chk("R7 no clear when wdt off", wdt_clr, 0);
        irq_en = 8'h04; tick(); irq_en = 0;
        // Deep sleep.
        deep_arm_wr = 1; deep_arm_wdata = 1; tick(); deep_arm_wr = 0;
        chk("R4 arm set", deep_arm, 1);
        wdt_en = 1; lprc_user_wdt = 1; cmd(1'b1);
        chk("R4 deep mem off", mem_pwr_en, 0);
        chk("R7 no clear on deep", wdt_clr, 0);
        chk("R8 lprc kept by wdt in deep", lprc_en, 1);
        irq_en = 8'hff; irq_req = 8'hff; wdt_timeout = 1; tick(); tick();
        irq_en = 0; irq_req = 0; wdt_timeout = 0;
        chk("R10 deep ignores lp wake", {mem_pwr_en, cpu_clk_en}, 8'h0);
        dswdt_timeout = 1; tick(); dswdt_timeout = 0;
        chk("R10 exit mem first", {mem_pwr_en, cpu_clk_en, io_freeze, deep_arm}, 8'ha);
        tick();
        chk("R10 run after exit", {cpu_clk_en, io_freeze}, 8'h2);
        lprc_user_wdt = 0;
        // Idle while armed stays idle.
        deep_arm_wr = 1; deep_arm_wdata = 1; tick(); deep_arm_wr = 0;
        cmd(1'b0);
        chk("R4 idle while armed", {cpu_clk_en, mem_pwr_en, per_clk_en}, 8'h3);
        wdt_timeout = 1; tick(); wdt_timeout = 0;
        chk("R5 wake idle on wdt", cpu_clk_en, 1);
        // Asynchronous reset in deep sleep.
        cmd(1'b1);
        #2 rst_n = 0; #1;
        chk("R11 async reset", {cpu_clk_en, per_clk_en, mem_pwr_en, io_freeze, deep_arm}, 8'h1c);
        chk("R11 reset sel", clk_sel, RSEL);
        tick(); rst_n = 1; tick(); tick();
        summary();
        $finish;
    end
endmodule